// File: doc/BRIEF.md
# Packet-Gated Dual-Clock Word FIFO

This block moves packets of data words from one clock domain to another. The two clocks run at the same nominal rate but come from separate oscillators, so they drift against each other. The producer presents each packet as an unbroken run of words and marks the final word with an end flag. It may pause only between packets. The consumer side holds back the start of a packet until enough words are buffered to cover the drift. After that start it delivers the packet on back-to-back read cycles until the end word has gone.

Each domain keeps its own binary pointer. The pointer crosses to the other domain as a Gray code through a chain of synchronizer flops. Each side works out its fill level from its own pointer and the synchronized copy of the other pointer. This makes both flags conservative. Empty rises in the same read cycle that removes the last stored word, but it clears only after a write has passed through the synchronizer. Full clears only after a read has passed through it. Almost-empty is registered and is advisory only. A packet that runs dry in the middle sets a sticky underflow flag. A word offered while the buffer is full sets a sticky overflow flag.

Both sides use valid/ready handshakes. A word moves on a clock edge where valid and ready are both high. On the write side, ready falls only when the buffer is full. The producer cannot stall inside a packet, so any word it offers while ready is low is dropped and is recorded as an overflow. On the read side, the consumer may hold ready low. Valid and the presented word then stay unchanged until the consumer takes the word.

Top module: `phit_cdc_fifo`

## Requirements
- R1: After both resets are released, empty and almost_empty are 1, and out_valid, overflow and underflow are 0. in_ready is 1.
- R2: Accepted words leave in the order they were written, each with its end flag intact. A word offered while in_ready is 0 never appears at the output.
- R3: For a new packet, out_valid rises only when the synchronized fill is at least START_FILL (default 2) words, or when the head word carries the end flag (a one-word packet).
- R4: Once a packet has started and the writer keeps pace, out_valid stays high on every read cycle with out_ready high until the end word is taken. The block then returns to idle, so the next packet is gated by R3 again.
- R5: empty is 1 in the read cycle right after the last stored word is taken. After a write into an empty FIFO, empty stays 1 for at least SYNC_STAGES (default 2) read edges.
- R6: almost_empty is 1 when the read-side fill is at most AE_LEVEL (default 1) words and 0 otherwise. It is registered and may lag by one read cycle.
- R7: If the FIFO is empty while a packet is streaming and out_ready is 1 before the end word, underflow becomes 1 and stays 1 until read reset. out_valid is 0 while empty, and the packet resumes when data arrives.
- R8: in_ready is 0 while DEPTH words (default 8) are held. A word offered then is refused, and overflow becomes 1 and stays 1 until write reset.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values on the next read cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain synchronous reset, active high |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | FIFO can accept a word |
| in_data | input | DATA_W | Word payload |
| in_last | input | 1 | Word ends its packet |
| overflow | output | 1 | Sticky: a word was offered while full |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain synchronous reset, active high |
| out_valid | output | 1 | A word of the current packet is presented |
| out_ready | input | 1 | Consumer takes the presented word |
| out_data | output | DATA_W | Presented word payload |
| out_last | output | 1 | Presented word ends its packet |
| empty | output | 1 | No word visible to the read side |
| almost_empty | output | 1 | Advisory low-fill warning |
| underflow | output | 1 | Sticky: a streaming packet ran dry |

## Verification
The bench runs the write clock slightly faster than the read clock and checks every read handshake against a queue model.

- **Fill-up start.** A packet's first word is left waiting alone in the FIFO. If the start threshold were evaluated only while draining, that packet would start early.
- **One-word packet.** A single-word packet must still be delivered. A design that waited for a second word would hang with the packet stuck inside.
- **Empty timing.** Empty is sampled immediately after the final word leaves, and again one read edge after a write. A late set or an early clear is reported there.
- **Full, hold and mid-packet dry-out.** The buffer is filled to capacity with the consumer stalled, then one extra word is offered. The packet is then allowed to run dry before its end word. A design that dropped the wrong word, lost stickiness of a flag, or kept valid high on an empty FIFO shows a mismatch at the ports.

// File: rtl/phit_fifo_pkg.sv
package phit_fifo_pkg;

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_WAIT   = 2'd1,
    RD_STREAM = 2'd2
  } rd_state_e;

endpackage

// File: rtl/phit_ptr_sync.sv
module phit_ptr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= gray_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  always_comb begin
    bin_out[W-1] = stg[STAGES-1][W-1];
    for (int i = W - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ stg[STAGES-1][i];
  end

endmodule

// File: rtl/phit_mem.sv
module phit_mem #(
  parameter int DW = 17,
  parameter int AW = 3
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_word,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word
);

  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] cells [ENTRIES];

  always_ff @(posedge wr_clk) begin
    if (wr_en) cells[wr_addr] <= wr_word;
  end

  assign rd_word = cells[rd_addr];

endmodule

// File: rtl/phit_wr_side.sv
module phit_wr_side #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW:0]   wr_gray,
  input  logic [AW:0]   rd_bin_sync,
  output logic          overflow
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_LVL = PW'(1) << AW;

  logic [PW-1:0] wr_bin, wr_bin_nxt, used;

  assign used       = wr_bin - rd_bin_sync;
  assign in_ready   = (used != FULL_LVL);
  assign wr_en      = in_valid && in_ready;
  assign wr_bin_nxt = wr_bin + PW'(1);
  assign wr_addr    = wr_bin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bin   <= '0;
      wr_gray  <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_en) begin
        wr_bin  <= wr_bin_nxt;
        wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
      end
      if (in_valid && !in_ready) overflow <= 1'b1;
    end
  end

  AST_GRAY_ONE_STEP: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_gray ^ $past(wr_gray))); // R2
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst) used <= FULL_LVL); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) overflow |=> overflow); // R8

endmodule

// File: rtl/phit_rd_side.sv
module phit_rd_side
  import phit_fifo_pkg::*;
#(
  parameter int AW         = 3,
  parameter int START_FILL = 2,
  parameter int AE_LEVEL   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          out_ready,
  input  logic          head_last,
  input  logic [AW:0]   wr_bin_sync,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0]   rd_gray,
  output logic          out_valid,
  output logic          empty,
  output logic          almost_empty,
  output logic          underflow
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] START_LVL = PW'(START_FILL);
  localparam logic [PW-1:0] AE_LVL    = PW'(AE_LEVEL);

  rd_state_e     state, state_nxt;
  logic [PW-1:0] rd_bin, rd_bin_nxt, used;
  logic          take;

  assign used       = wr_bin_sync - rd_bin;
  assign empty      = (used == '0);
  assign out_valid  = (state == RD_STREAM) && !empty;
  assign take       = out_valid && out_ready;
  assign rd_bin_nxt = rd_bin + PW'(1);
  assign rd_addr    = rd_bin[AW-1:0];

  always_comb begin
    state_nxt = state;
    unique case (state)
      RD_IDLE:   if (!empty) state_nxt = RD_WAIT;
      RD_WAIT:   if (used >= START_LVL || head_last) state_nxt = RD_STREAM;
      RD_STREAM: if (take && head_last) state_nxt = RD_IDLE;
      default:   state_nxt = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= RD_IDLE;
      rd_bin       <= '0;
      rd_gray      <= '0;
      almost_empty <= 1'b1;
      underflow    <= 1'b0;
    end else begin
      state        <= state_nxt;
      almost_empty <= (used <= AE_LVL);
      if (take) begin
        rd_bin  <= rd_bin_nxt;
        rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
      end
      if (state == RD_STREAM && empty && out_ready) underflow <= 1'b1;
    end
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (rst) ($rose(out_valid) && $past(state) != RD_STREAM) |-> (used >= START_LVL || head_last)); // R3
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst) underflow |=> underflow); // R7
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |=> (out_valid && $stable(rd_gray))); // R9

endmodule

// File: rtl/phit_cdc_fifo.sv
module phit_cdc_fifo #(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 8,
  parameter int START_FILL  = 2,
  parameter int AE_LEVEL    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              overflow,
  input  logic              rd_clk,
  input  logic              rd_rst,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              empty,
  output logic              almost_empty,
  output logic              underflow
);

  // DEPTH must be a power of two, at least 8
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int MW = DATA_W + 1;

  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] wr_gray, rd_gray, wr_bin_sync, rd_bin_sync;
  logic [MW-1:0] rd_word;

  phit_wr_side #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .in_valid(in_valid), .in_ready(in_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_gray(wr_gray),
    .rd_bin_sync(rd_bin_sync), .overflow(overflow)
  );

  phit_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rd2wr (
    .clk(wr_clk), .rst(wr_rst), .gray_in(rd_gray), .bin_out(rd_bin_sync)
  );

  phit_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wr2rd (
    .clk(rd_clk), .rst(rd_rst), .gray_in(wr_gray), .bin_out(wr_bin_sync)
  );

  phit_mem #(.DW(MW), .AW(AW)) u_mem (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_word({in_last, in_data}), .rd_addr(rd_addr), .rd_word(rd_word)
  );

  assign out_last = rd_word[MW-1];
  assign out_data = rd_word[DATA_W-1:0];

  phit_rd_side #(.AW(AW), .START_FILL(START_FILL), .AE_LEVEL(AE_LEVEL)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .out_ready(out_ready), .head_last(out_last),
    .wr_bin_sync(wr_bin_sync), .rd_addr(rd_addr), .rd_gray(rd_gray),
    .out_valid(out_valid), .empty(empty), .almost_empty(almost_empty),
    .underflow(underflow)
  );

endmodule

// File: tb/tb_phit_cdc_fifo.sv
`timescale 1ns/10ps
module tb_phit_cdc_fifo;

  logic wr_clk = 1'b0, rd_clk = 1'b0, wr_rst = 1'b1, rd_rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready, overflow, out_valid, out_last, empty, almost_empty, underflow;
  logic [15:0] out_data;

  always #5    wr_clk = ~wr_clk;
  always #5.05 rd_clk = ~rd_clk;

  phit_cdc_fifo dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .overflow(overflow),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .empty(empty),
    .almost_empty(almost_empty), .underflow(underflow)
  );

  int checks = 0, errors = 0;
  bit done = 0, gap_en = 0, in_pkt = 0, pend_empty = 0, prev_valid = 0;
  logic [16:0] q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_burst(input int n, input logic [15:0] base, input bit last_end);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      in_valid = 1'b1;
      in_data  = base + 16'(i);
      in_last  = last_end && (i == n - 1);
      if (in_ready) q.push_back({in_last, in_data});
      @(posedge wr_clk);
    end
    #1 in_valid = 1'b0;
    in_last = 1'b0;
  endtask

  task automatic rd_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge rd_clk);
  endtask

  // reference model: every read handshake against the queue
  always @(negedge rd_clk) begin
    if (!rd_rst && !done) begin
      if (pend_empty && q.size() == 0) check(empty == 1'b1, "R5 empty after last word", 32'(empty), 1);
      pend_empty = 0;
      if (out_valid && !prev_valid && !in_pkt)
        check(q.size() >= 2 || (q.size() >= 1 && q[0][16]), "R3 start threshold", 32'(q.size()), 2);
      if (gap_en && in_pkt && out_ready && !out_valid) check(1'b0, "R4 gap in packet", 0, 1);
      if (out_valid && out_ready) begin
        if (q.size() == 0) check(1'b0, "R2 unexpected word", 32'({out_last, out_data}), 0);
        else begin
          logic [16:0] exp;
          exp = q.pop_front();
          check({out_last, out_data} == exp, "R2 data order", 32'({out_last, out_data}), 32'(exp));
          in_pkt = !exp[16];
          if (exp[16]) pend_empty = 1;
        end
      end
      prev_valid = out_valid;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge wr_clk);
    wr_rst = 1'b0;
    @(negedge rd_clk);
    rd_rst = 1'b0;
    rd_wait(3);
    check(empty == 1, "R1 empty", 32'(empty), 1);
    check(almost_empty == 1, "R1 almost_empty", 32'(almost_empty), 1);
    check(out_valid == 0, "R1 out_valid", 32'(out_valid), 0);
    check(in_ready == 1, "R1 in_ready", 32'(in_ready), 1);
    check(overflow == 0 && underflow == 0, "R1 flags", 32'({overflow, underflow}), 0);

    // lone first word of a packet: fill-up start must not trigger
    out_ready = 1'b1;
    write_burst(1, 16'h0100, 1'b0);
    @(negedge rd_clk);
    check(empty == 1, "R5 empty lags write", 32'(empty), 1);
    rd_wait(30);
    check(out_valid == 0, "R3 one word held", 32'(out_valid), 0);
    check(empty == 0, "R5 empty cleared", 32'(empty), 0);
    check(almost_empty == 1, "R6 fill of one", 32'(almost_empty), 1);
    write_burst(3, 16'h0101, 1'b1);
    rd_wait(30);
    check(q.size() == 0, "R2 packet drained", 32'(q.size()), 0);

    // one-word packet
    write_burst(1, 16'h0200, 1'b1);
    rd_wait(30);
    check(q.size() == 0, "R3 single-word packet", 32'(q.size()), 0);

    // long packet streamed without gaps
    gap_en = 1;
    write_burst(24, 16'h0300, 1'b1);
    rd_wait(40);
    gap_en = 0;
    check(q.size() == 0, "R4 long packet drained", 32'(q.size()), 0);
    check(underflow == 0, "R4 no underflow", 32'(underflow), 0);

    // stalled consumer: hold, full, overflow, then dry-out
    out_ready = 1'b0;
    write_burst(3, 16'h0400, 1'b0);
    rd_wait(30);
    check(out_valid == 1, "R3 started at three", 32'(out_valid), 1);
    check(almost_empty == 0, "R6 fill of three", 32'(almost_empty), 0);
    check(out_data == 16'h0400, "R9 head word", 32'(out_data), 32'h400);
    rd_wait(5);
    check(out_valid == 1 && out_data == 16'h0400 && out_last == 0, "R9 hold under stall", 32'(out_data), 32'h400);
    write_burst(5, 16'h0403, 1'b0);
    repeat (20) @(negedge wr_clk);
    check(in_ready == 0, "R8 full", 32'(in_ready), 0);
    check(q.size() == 8, "R8 accepted count", 32'(q.size()), 8);
    write_burst(1, 16'h0408, 1'b0);
    @(negedge wr_clk);
    check(overflow == 1, "R8 overflow set", 32'(overflow), 1);
    check(q.size() == 8, "R8 refused word", 32'(q.size()), 8);
    out_ready = 1'b1;
    rd_wait(40);
    check(out_valid == 0, "R7 valid dropped", 32'(out_valid), 0);
    check(underflow == 1, "R7 underflow set", 32'(underflow), 1);
    check(q.size() == 0, "R2 full packet out", 32'(q.size()), 0);
    write_burst(1, 16'h0409, 1'b1);
    rd_wait(30);
    check(q.size() == 0, "R7 packet resumed", 32'(q.size()), 0);
    check(underflow == 1, "R7 underflow sticky", 32'(underflow), 1);
    check(overflow == 1, "R8 overflow sticky", 32'(overflow), 1);
    check(in_ready == 1, "R8 ready again", 32'(in_ready), 1);

    finish_run();
  end

endmodule